// File: doc/BRIEF.md
# Core Mode Reconfiguration Sequencer

This block changes a resizable out-of-order core from one of four execution modes to another. A requester presents a target mode for one cycle. The sequencer looks up how many banks of the issue queue, the load/store queue and the reorder buffer that mode needs. It raises a busy/stall signal and waits for the pipeline to report that it is empty. It then turns banks on or off one at a time, and each bank costs a fixed number of cycles. After that it applies the new fetch width, decoder enable and frequency code, and holds the core for a fixed voltage/frequency settling phase. At the end it drops busy and pulses done together with the mode now active.

The mode encoding is 0 = average, 1 = narrow, 2 = larger and 3 = smaller. Queue banks hold 12 issue-queue entries or 16 load/store or reorder entries each. A request for the mode that is already active is acknowledged at once. A request that arrives during a switch is held, and it is served when the switch completes.

Top module: `core_mode_seq`

## Requirements
- R1: After reset the active mode is average (0). The outputs are iq_bank_en = 4'b0111, lsq_bank_en = 8'hFF, rob_bank_en = 16'h00FF, fetch_width = 4, dec_upper_en = 1, freq_code = 16, busy = 0 and done = 0.
- R2: Each mode has its own bank counts, given as IQ/LSQ/ROB. Average (0) uses 3/8/8, narrow (1) uses 2/4/4, larger (2) uses 4/8/16 and smaller (3) uses 1/1/1.
- R3: Fetch width is 4, 2, 4 and 1 for modes 0 to 3. freq_code is the clock in units of 100 MHz: 16, 20, 14 and 12 for modes 0 to 3. dec_upper_en is 1 only when the width is 4.
- R4: Every bank-enable vector is a thermometer code. With n banks on, bits 0 to n-1 are set and all other bits are clear.
- R5: A request for the active mode gives done = 1 with done_mode equal to that mode in the next cycle. busy does not rise.
- R6: While pipe_empty is low after a switch has started, busy stays high and no bank enable changes.
- R7: Banks change one at a time, one step every 10 cycles. All IQ steps come first, then LSQ, then ROB. With pipe_empty held high, busy stays high for exactly 202 + 10*k cycles, where k is the total number of banks toggled.
- R8: Fetch width, decoder enable and freq_code change only when gating ends. A 200-cycle settling phase follows. done then pulses for one cycle, and done_mode gives the new mode.
- R9: A request that arrives while busy is held, and a later one overwrites it. It starts in the cycle after done.
- R10: busy and done are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle mode change request |
| req_mode | input | 2 | Requested mode (0 avg, 1 narrow, 2 larger, 3 smaller) |
| pipe_empty | input | 1 | Pipeline is fully drained |
| busy | output | 1 | Stall: a switch is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_mode | output | 2 | Currently active mode |
| iq_bank_en | output | 4 | Issue-queue bank enables |
| lsq_bank_en | output | 8 | Load/store-queue bank enables |
| rob_bank_en | output | 16 | Reorder-buffer bank enables |
| dec_upper_en | output | 1 | Enable for the upper half of the decoders |
| fetch_width | output | 3 | Fetch/issue width (1, 2 or 4) |
| freq_code | output | 5 | Target clock in units of 100 MHz |

## Verification
The completion of one switch and the acceptance of the next request can land on the same cycle. The bench provokes this in two ways. First, it pulses a new request in the very cycle that done is high. Second, it leaves a request held from the middle of a switch so that it is picked up as done fires. In both cases the bench expects done to be clear of busy in that cycle, and busy to rise in the following cycle. It then checks that the second switch reaches the mode that was requested last.

// File: rtl/cms_pkg.sv
// Package: shared mode encoding and per-mode configuration functions.
// Assumes banks are uniform within a structure; bank counts round up.
package cms_pkg;
    typedef enum logic [1:0] {
        MODE_AVG    = 2'd0,
        MODE_NARROW = 2'd1,
        MODE_LARGE  = 2'd2,
        MODE_SMALL  = 2'd3
    } core_mode_e;

    localparam int IQ_BANK_SZ  = 12;
    localparam int LSQ_BANK_SZ = 16;
    localparam int ROB_BANK_SZ = 16;

    function automatic int iq_entries(input logic [1:0] m);
        case (m)
            2'd0:    return 36;
            2'd1:    return 24;
            2'd2:    return 48;
            default: return 12;
        endcase
    endfunction

    function automatic int lsq_entries(input logic [1:0] m);
        case (m)
            2'd0:    return 128;
            2'd1:    return 64;
            2'd2:    return 128;
            default: return 16;
        endcase
    endfunction

    function automatic int rob_entries(input logic [1:0] m);
        case (m)
            2'd0:    return 128;
            2'd1:    return 64;
            2'd2:    return 256;
            default: return 16;
        endcase
    endfunction

    function automatic int mode_width(input logic [1:0] m);
        case (m)
            2'd0:    return 4;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 1;
        endcase
    endfunction

    // Clock in units of 100 MHz
    function automatic int mode_freq(input logic [1:0] m);
        case (m)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 14;
            default: return 12;
        endcase
    endfunction

    localparam int IQ_NB  = (iq_entries(2'd2)  + IQ_BANK_SZ  - 1) / IQ_BANK_SZ;
    localparam int LSQ_NB = (lsq_entries(2'd0) + LSQ_BANK_SZ - 1) / LSQ_BANK_SZ;
    localparam int ROB_NB = (rob_entries(2'd2) + ROB_BANK_SZ - 1) / ROB_BANK_SZ;
    localparam int IQ_CW  = $clog2(IQ_NB + 1);
    localparam int LSQ_CW = $clog2(LSQ_NB + 1);
    localparam int ROB_CW = $clog2(ROB_NB + 1);
endpackage

// File: rtl/cms_mode_table.sv
// Module: cms_mode_table
// Combinational decode of a mode into bank goals, width and frequency code.
// Assumes the package functions describe every mode value.
module cms_mode_table
    import cms_pkg::*;
(
    input  logic [1:0]        mode,
    output logic [IQ_CW-1:0]  iq_goal,
    output logic [LSQ_CW-1:0] lsq_goal,
    output logic [ROB_CW-1:0] rob_goal,
    output logic [2:0]        width,
    output logic [4:0]        freq
);
    // Derive bank counts by rounding entries up to whole banks
    always_comb begin
        iq_goal  = IQ_CW'((iq_entries(mode)  + IQ_BANK_SZ  - 1) / IQ_BANK_SZ);
        lsq_goal = LSQ_CW'((lsq_entries(mode) + LSQ_BANK_SZ - 1) / LSQ_BANK_SZ);
        rob_goal = ROB_CW'((rob_entries(mode) + ROB_BANK_SZ - 1) / ROB_BANK_SZ);
        width    = 3'(mode_width(mode));
        freq     = 5'(mode_freq(mode));
    end
endmodule

// File: rtl/cms_bank_stepper.sv
// Module: cms_bank_stepper
// Holds the number of powered banks of one structure and moves it one bank
// toward a goal on each step pulse; drives a thermometer enable vector.
// Assumes step is pulsed no more often than the bank power cost allows.
module cms_bank_stepper #(
    parameter int NB     = 4,
    parameter int RST_ON = 3,
    parameter int CW     = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] goal,
    output logic [CW-1:0] on_cnt,
    output logic [NB-1:0] bank_en,
    output logic          at_goal
);
    // Move one bank toward the goal per step
    always_ff @(posedge clk) begin
        if (!rst_n)
            on_cnt <= CW'(RST_ON);
        else if (step && on_cnt != goal)
            on_cnt <= (on_cnt < goal) ? on_cnt + 1'b1 : on_cnt - 1'b1;
    end

    assign at_goal = (on_cnt == goal);

    // Thermometer: bank i powered when count exceeds i
    for (genvar i = 0; i < NB; i++) begin : g_en
        assign bank_en[i] = (on_cnt > CW'(i));
    end

    // R7
    single_bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(on_cnt) |-> ($past(step) &&
            (int'(on_cnt) - int'($past(on_cnt)) == 1 ||
             int'($past(on_cnt)) - int'(on_cnt) == 1)));
    // R4
    thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_en) == int'(on_cnt));
endmodule

// File: rtl/core_mode_seq.sv
// Module: core_mode_seq
// Sequences a core mode switch: drain wait, bank gating one bank per
// BANK_CYC cycles (IQ, then LSQ, then ROB), then a DVFS_CYC settling phase.
// Assumes pipe_empty is driven by the core and stays valid while busy.
module core_mode_seq
    import cms_pkg::*;
#(
    parameter int BANK_CYC = 10,
    parameter int DVFS_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic              pipe_empty,
    output logic              busy,
    output logic              done,
    output logic [1:0]        done_mode,
    output logic [IQ_NB-1:0]  iq_bank_en,
    output logic [LSQ_NB-1:0] lsq_bank_en,
    output logic [ROB_NB-1:0] rob_bank_en,
    output logic              dec_upper_en,
    output logic [2:0]        fetch_width,
    output logic [4:0]        freq_code
);
    localparam int TMAX = (DVFS_CYC > BANK_CYC) ? DVFS_CYC : BANK_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_GATE, ST_DVFS} seq_state_e;

    seq_state_e        state;
    logic [TW-1:0]     timer;
    logic [1:0]        cur_mode, tgt_mode, pend_mode, pick_mode;
    logic              pend_v, take;
    logic [IQ_CW-1:0]  iq_goal, iq_cnt;
    logic [LSQ_CW-1:0] lsq_goal, lsq_cnt;
    logic [ROB_CW-1:0] rob_goal, rob_cnt;
    logic [2:0]        tgt_width;
    logic [4:0]        tgt_freq;
    logic              iq_at, lsq_at, rob_at, gate_tick;
    logic              iq_step, lsq_step, rob_step;

    cms_mode_table u_table (
        .mode(tgt_mode), .iq_goal(iq_goal), .lsq_goal(lsq_goal),
        .rob_goal(rob_goal), .width(tgt_width), .freq(tgt_freq)
    );

    // One step every BANK_CYC cycles, structures in fixed order
    assign gate_tick = (state == ST_GATE) && (timer == TW'(BANK_CYC - 1));
    assign iq_step   = gate_tick && !iq_at;
    assign lsq_step  = gate_tick && iq_at && !lsq_at;
    assign rob_step  = gate_tick && iq_at && lsq_at && !rob_at;

    cms_bank_stepper #(.NB(IQ_NB), .RST_ON(3), .CW(IQ_CW)) u_iq (
        .clk(clk), .rst_n(rst_n), .step(iq_step), .goal(iq_goal),
        .on_cnt(iq_cnt), .bank_en(iq_bank_en), .at_goal(iq_at));
    cms_bank_stepper #(.NB(LSQ_NB), .RST_ON(8), .CW(LSQ_CW)) u_lsq (
        .clk(clk), .rst_n(rst_n), .step(lsq_step), .goal(lsq_goal),
        .on_cnt(lsq_cnt), .bank_en(lsq_bank_en), .at_goal(lsq_at));
    cms_bank_stepper #(.NB(ROB_NB), .RST_ON(8), .CW(ROB_CW)) u_rob (
        .clk(clk), .rst_n(rst_n), .step(rob_step), .goal(rob_goal),
        .on_cnt(rob_cnt), .bank_en(rob_bank_en), .at_goal(rob_at));

    // A live request wins over a held one when idle
    assign take      = req_valid || pend_v;
    assign pick_mode = req_valid ? req_mode : pend_mode;

    // Main sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            timer        <= '0;
            cur_mode     <= MODE_AVG;
            tgt_mode     <= MODE_AVG;
            pend_v       <= 1'b0;
            pend_mode    <= MODE_AVG;
            done         <= 1'b0;
            fetch_width  <= 3'd4;
            dec_upper_en <= 1'b1;
            freq_code    <= 5'd16;
        end else begin
            done <= 1'b0;
            if (state != ST_IDLE && req_valid) begin
                pend_v    <= 1'b1;
                pend_mode <= req_mode;
            end
            case (state)
                ST_IDLE: if (take) begin
                    pend_v <= 1'b0;
                    if (pick_mode == cur_mode) begin
                        done <= 1'b1;
                    end else begin
                        tgt_mode <= pick_mode;
                        state    <= ST_DRAIN;
                    end
                end
                ST_DRAIN: if (pipe_empty) begin
                    state <= ST_GATE;
                    timer <= '0;
                end
                ST_GATE: begin
                    if (iq_at && lsq_at && rob_at) begin
                        state        <= ST_DVFS;
                        timer        <= '0;
                        fetch_width  <= tgt_width;
                        dec_upper_en <= (tgt_width == 3'd4);
                        freq_code    <= tgt_freq;
                    end else if (gate_tick) begin
                        timer <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: begin
                    if (timer == TW'(DVFS_CYC - 1)) begin
                        state    <= ST_IDLE;
                        cur_mode <= tgt_mode;
                        done     <= 1'b1;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done_mode = cur_mode;

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R6
    no_gate_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |=> $stable({iq_bank_en, lsq_bank_en, rob_bank_en}));
    // R8
    freq_at_gate_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_code) |-> ($past(state) == ST_GATE && state == ST_DVFS));
    // R7
    one_struct_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!$stable(iq_cnt), !$stable(lsq_cnt), !$stable(rob_cnt)}) <= 1);
endmodule

// File: tb/tb_core_mode_seq.sv
module tb_core_mode_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic        pipe_empty = 1'b1;
    logic        busy, done, dec_upper_en;
    logic [1:0]  done_mode;
    logic [3:0]  iq_bank_en;
    logic [7:0]  lsq_bank_en;
    logic [15:0] rob_bank_en;
    logic [2:0]  fetch_width;
    logic [4:0]  freq_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    core_mode_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .pipe_empty(pipe_empty), .busy(busy), .done(done), .done_mode(done_mode),
        .iq_bank_en(iq_bank_en), .lsq_bank_en(lsq_bank_en), .rob_bank_en(rob_bank_en),
        .dec_upper_en(dec_upper_en), .fetch_width(fetch_width), .freq_code(freq_code)
    );

    // Columns: mode, iq banks, lsq banks, rob banks, width, freq
    localparam int NV = 6;
    localparam int TBL [NV][6] = '{
        '{1, 2, 4, 4, 2, 20},
        '{2, 4, 8, 16, 4, 14},
        '{3, 1, 1, 1, 1, 12},
        '{0, 3, 8, 8, 4, 16},
        '{3, 1, 1, 1, 1, 12},
        '{1, 2, 4, 4, 2, 20}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Issue a one-cycle request, aligned to negedge
    task automatic request(input int m);
        req_valid = 1'b1;
        req_mode  = 2'(m);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Count busy cycles until done; a hang counts as a failure
    task automatic wait_done(output int bcnt);
        bcnt = 0;
        for (int i = 0; i < 5000; i++) begin
            if (done) return;
            if (busy) bcnt++;
            @(negedge clk);
        end
        chk(1'b0, "watchdog", bcnt, -1);
    endtask

    task automatic chk_cfg(input string rq, input int iq, input int lsq,
                           input int rob, input int w, input int f);
        chk(int'(iq_bank_en) == (1 << iq) - 1, {rq, " iq_en"}, int'(iq_bank_en), (1 << iq) - 1);
        chk(int'(lsq_bank_en) == (1 << lsq) - 1, {rq, " lsq_en"}, int'(lsq_bank_en), (1 << lsq) - 1);
        chk(int'(rob_bank_en) == (1 << rob) - 1, {rq, " rob_en"}, int'(rob_bank_en), (1 << rob) - 1);
        chk(int'(fetch_width) == w, {rq, " width"}, int'(fetch_width), w);
        chk(int'(dec_upper_en) == (w == 4 ? 1 : 0), {rq, " dec"}, int'(dec_upper_en), w == 4 ? 1 : 0);
        chk(int'(freq_code) == f, {rq, " freq"}, int'(freq_code), f);
    endtask

    // R10 monitor on every cycle
    always @(negedge clk) if (rst_n && busy && done) chk(1'b0, "R10 busy&done", 1, 0);

    initial begin
        int bc;
        int pi, pl, pr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_cfg("R1", 3, 8, 8, 4, 16);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'(busy), 0);
        chk(done_mode == 2'd0, "R1 mode", int'(done_mode), 0);

        // R2 R3 R7 R8 table walk
        pi = 3; pl = 8; pr = 8;
        for (int v = 0; v < NV; v++) begin
            int k;
            k = absd(pi, TBL[v][1]) + absd(pl, TBL[v][2]) + absd(pr, TBL[v][3]);
            request(TBL[v][0]);
            wait_done(bc);
            chk(bc == 202 + 10 * k, "R7 busy length", bc, 202 + 10 * k);
            chk(int'(done_mode) == TBL[v][0], "R8 done_mode", int'(done_mode), TBL[v][0]);
            chk_cfg("R2/R3", TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], TBL[v][5]);
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
            pi = TBL[v][1]; pl = TBL[v][2]; pr = TBL[v][3];
        end

        // R7 ordering: narrow -> average, IQ step first, then LSQ
        request(0);
        repeat (11) @(negedge clk);
        chk(iq_bank_en == 4'b0111, "R7 iq first", int'(iq_bank_en), 7);
        chk(lsq_bank_en == 8'h0F, "R7 lsq waits", int'(lsq_bank_en), 15);
        chk(fetch_width == 3'd2, "R8 width held during gating", int'(fetch_width), 2);
        repeat (10) @(negedge clk);
        chk(lsq_bank_en == 8'h1F, "R7 lsq second", int'(lsq_bank_en), 31);
        wait_done(bc);
        chk(done_mode == 2'd0, "R7 end mode", int'(done_mode), 0);
        @(negedge clk);

        // R6 drain hold: average -> narrow with pipe not empty
        pipe_empty = 1'b0;
        request(1);
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R6 busy", int'(busy), 1);
        chk(rob_bank_en == 16'h00FF, "R6 rob held", int'(rob_bank_en), 255);
        chk(iq_bank_en == 4'b0111, "R6 iq held", int'(iq_bank_en), 7);
        pipe_empty = 1'b1;
        wait_done(bc);
        chk(rob_bank_en == 16'h000F, "R6 after drain", int'(rob_bank_en), 15);
        @(negedge clk);

        // R9 held request: start smaller, then ask narrow then larger while busy
        request(3);
        repeat (5) @(negedge clk);
        request(1);
        repeat (5) @(negedge clk);
        request(2);
        wait_done(bc);
        chk(done_mode == 2'd3, "R9 first done", int'(done_mode), 3);
        @(negedge clk);
        chk(busy == 1'b1, "R9 held starts", int'(busy), 1);
        wait_done(bc);
        chk(done_mode == 2'd2, "R9 latest wins", int'(done_mode), 2);
        chk_cfg("R9", 4, 8, 16, 4, 14);

        // R5 same mode request while idle
        @(negedge clk);
        request(2);
        chk(done == 1'b1 && busy == 1'b0, "R5 immediate done", int'(done), 1);
        chk(done_mode == 2'd2, "R5 mode", int'(done_mode), 2);

        // Request landing in the done cycle
        request(3);
        chk(busy == 1'b1 && done == 1'b0, "R9 req on done cycle", int'(busy), 1);
        wait_done(bc);
        chk(done_mode == 2'd3, "R9 on-done mode", int'(done_mode), 3);
        @(negedge clk);
        chk(busy == 1'b0, "R5 idle after", int'(busy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule